// File: doc/BRIEF.md
# Stream Stall Timeout Timer

This block watches a streaming output that is being held back by its downstream consumer while a DMA transfer still has data left to move. When the timer is enabled, a transfer is pending and the sink is not ready, the block arms. It then divides the core clock with a programmable prescaler and counts a programmable number of those divided ticks. If the stall lasts through the whole count, the block raises a single-cycle timeout pulse. An interrupt-status flag elsewhere in the engine can latch that pulse.

Any sign of progress stops the timer at once: the sink becoming ready, the pending indication dropping, or the enable being cleared. The next stall re-arms it from scratch. After it has fired, the timer stays quiet until the stall has ended. It therefore reports each stall episode at most once.

Top module: `stream_stall_timer`

## Requirements
- R1: While reset is high, and in the first cycle after it, `timeout_pulse` is 0.
- R2: The timer arms only on a clock edge where `enable`=1, `pending`=1 and `sink_ready`=0 all hold (a "stall" edge). Without continuous stall edges, no pulse is ever produced.
- R3: The prescaler yields one tick every `presc_val`+1 cycles. If the stall lasts long enough, `timeout_pulse` goes high after the edge that lies N·(`presc_val`+1) edges after the arming edge, where N = `tmo_val`.
- R4: `timeout_pulse` is high for exactly one clock cycle per expiry.
- R5: After an expiry, no further pulse occurs until at least one non-stall edge has passed, even if the stall continues indefinitely. A later stall re-arms the timer and can fire again.
- R6: A non-stall edge (`sink_ready`=1 or `pending`=0) stops the timer. It wins over an expiry that would fall on the same edge. The next stall restarts the full count.
- R7: Clearing `enable` before expiry suppresses the pulse for that arming.
- R8: `presc_val` and `tmo_val` are captured on the arming edge. Changes made while the timer runs do not affect the expiry time.
- R9: A `tmo_val` of 0 behaves as a count of one tick, so expiry comes `presc_val`+1 edges after arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Timeout function enable |
| presc_val | input | PRE_W (12) | Prescaler divide value; the tick period is this value + 1 |
| tmo_val | input | CNT_W (12) | Number of prescaled ticks before timeout (0 counts as 1) |
| pending | input | 1 | High while the transfer's remaining size is nonzero |
| sink_ready | input | 1 | Downstream can accept data |
| timeout_pulse | output | 1 | One-cycle stream-timeout event |

## Verification
Two events can fall on the same clock edge: the expiry tick and the release of the stall. The bench provokes this by arming with a small prescaler and count, then raising `sink_ready` (and, in another run, dropping `pending`) on exactly the edge where the final tick would land. The reference model ranks stop above expiry, so it expects no pulse on that edge or afterwards. The bench judges the outcome both by comparing every cycle and by counting pulses over the episode. A second coincidence also gets its own run: a fresh stall that begins right after an expiry has been released. That run confirms the timer re-arms and fires once more.

// File: rtl/stt_pkg.sv
package stt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_SPENT = 2'd2
  } stt_state_e;
endpackage

// File: rtl/stt_prescaler.sv
// Divides the clock: one tick every (captured divide value + 1) cycles while run is high.
module stt_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [PRE_W-1:0] div_val,
  output logic             tick
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      div_q <= div_val;
      cnt_q <= div_val;
    end else if (run) begin
      if (cnt_q == '0) cnt_q <= div_q;
      else             cnt_q <= cnt_q - PRE_W'(1);
    end
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/stt_countdown.sv
// Counts prescaled ticks down from the captured timeout value; a value of 0 acts as 1.
module stt_countdown #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] init_val,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load)                cnt_q <= init_val;
    else if (tick && cnt_q > ONE) cnt_q <= cnt_q - ONE;
  end

  assign expire = tick && (cnt_q <= ONE);
endmodule

// File: rtl/stt_ctrl.sv
// Arming / stop / one-shot control with a registered pulse output.
module stt_ctrl
  import stt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stall,
  input  logic expire,
  output logic load,
  output logic run,
  output logic pulse
);
  stt_state_e state_q, state_d;

  assign load = (state_q == ST_IDLE) && stall;
  assign run  = (state_q == ST_RUN) && stall;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (stall) state_d = ST_RUN;
      ST_RUN: begin
        if (!stall)      state_d = ST_IDLE;
        else if (expire) state_d = ST_SPENT;
      end
      ST_SPENT: if (!stall) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      pulse   <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse   <= run && expire;
    end
  end
endmodule

// File: rtl/stream_stall_timer.sv
module stream_stall_timer #(
  parameter int PRE_W = 12,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [PRE_W-1:0] presc_val,
  input  logic [CNT_W-1:0] tmo_val,
  input  logic             pending,
  input  logic             sink_ready,
  output logic             timeout_pulse
);
  logic stall;
  logic load;
  logic run;
  logic tick;
  logic expire;

  assign stall = enable && pending && !sink_ready;

  stt_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .stall  (stall),
    .expire (expire),
    .load   (load),
    .run    (run),
    .pulse  (timeout_pulse)
  );

  stt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .run     (run),
    .div_val (presc_val),
    .tick    (tick)
  );

  stt_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .tick     (tick),
    .init_val (tmo_val),
    .expire   (expire)
  );
endmodule

// File: rtl/stt_checker.sv
module stt_checker (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic pending,
  input logic sink_ready,
  input logic timeout_pulse
);
  logic stall_now;
  logic fired_q;
  logic rst_q;

  assign stall_now = enable && pending && !sink_ready;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)             fired_q <= 1'b0;
    else if (!stall_now) fired_q <= 1'b0;
    else if (timeout_pulse) fired_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_q) AST_RESET_QUIET: assert (!timeout_pulse); // R1
  end

  AST_NEEDS_STALL: assert property (@(posedge clk) disable iff (rst)
    timeout_pulse |-> $past(pending) && !$past(sink_ready)); // R2

  AST_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    timeout_pulse |=> !timeout_pulse); // R4

  AST_ONCE_PER_ARM: assert property (@(posedge clk) disable iff (rst)
    timeout_pulse |-> !fired_q); // R5

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (rst)
    (sink_ready || !pending) |=> !timeout_pulse); // R6

  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !timeout_pulse); // R7
endmodule

bind stream_stall_timer stt_checker u_stt_chk (
  .clk           (clk),
  .rst           (rst),
  .enable        (enable),
  .pending       (pending),
  .sink_ready    (sink_ready),
  .timeout_pulse (timeout_pulse)
);

// File: tb/tb_stream_stall_timer.sv
module tb_stream_stall_timer;
  localparam int CLK_PERIOD = 10;
  localparam int PRE_W = 12;
  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             enable = 1'b0;
  logic [PRE_W-1:0] presc_val = '0;
  logic [CNT_W-1:0] tmo_val = '0;
  logic             pending = 1'b0;
  logic             sink_ready = 1'b1;
  logic             timeout_pulse;

  int    n_checks = 0;
  int    n_errors = 0;
  int    pulses = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_armed = 0, m_fired = 0, m_exp = 0;
  int m_elapsed = 0, m_pre = 0, m_tmo = 0;

  stream_stall_timer #(.PRE_W(PRE_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .enable(enable), .presc_val(presc_val),
    .tmo_val(tmo_val), .pending(pending), .sink_ready(sink_ready),
    .timeout_pulse(timeout_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    bit stall;
    stall = enable && pending && !sink_ready;
    m_exp = 0;
    if (rst) begin
      m_armed = 0; m_fired = 0;
    end else if (!stall) begin
      m_armed = 0; m_fired = 0;
    end else if (m_fired) begin
      m_fired = 1;
    end else if (!m_armed) begin
      m_armed = 1; m_elapsed = 0;
      m_pre = int'(presc_val); m_tmo = int'(tmo_val);
    end else begin
      m_elapsed++;
      if (m_elapsed == ((m_tmo == 0) ? 1 : m_tmo) * (m_pre + 1)) begin
        m_exp = 1; m_fired = 1; m_armed = 0;
      end
    end
  end

  always @(negedge clk) begin
    n_checks++;
    if (timeout_pulse !== m_exp) begin
      n_errors++;
      $display("FAIL %s: cycle compare timeout_pulse=%0b expected=%0b at %0t",
               cur_req, timeout_pulse, m_exp, $time);
    end
    if (timeout_pulse === 1'b1) pulses++;
  end

  task automatic chk(input string req, input int act, input int exp_v);
    n_checks++;
    if (act != exp_v) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic drive(input bit en, input bit pend, input bit rdy, input int cyc);
    enable = en; pending = pend; sink_ready = rdy;
    repeat (cyc) @(negedge clk);
  endtask

  task automatic setv(input int p, input int t);
    presc_val = PRE_W'(p); tmo_val = CNT_W'(t);
  endtask

  initial begin
    @(negedge clk);
    chk("R1 pulse during reset", int'(timeout_pulse), 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pulse after reset", int'(timeout_pulse), 0);

    // R3: basic expiry, P=2 T=3 -> 9 edges after arming
    cur_req = "R3"; setv(2, 3); pulses = 0;
    drive(1, 1, 0, 30);
    chk("R3 one pulse P=2 T=3", pulses, 1);
    drive(1, 1, 1, 3);

    // R3: no prescale, P=0 T=5
    cur_req = "R3"; setv(0, 5); pulses = 0;
    drive(1, 1, 0, 20);
    chk("R3 one pulse P=0 T=5", pulses, 1);
    drive(1, 0, 0, 3);

    // R9: zero count acts as one tick
    cur_req = "R9"; setv(3, 0); pulses = 0;
    drive(1, 1, 0, 12);
    chk("R9 one pulse T=0", pulses, 1);
    drive(1, 1, 1, 3);

    // R5: one pulse over a long stall, then re-arm fires again
    cur_req = "R5"; setv(0, 2); pulses = 0;
    drive(1, 1, 0, 40);
    chk("R5 single pulse long stall", pulses, 1);
    drive(1, 1, 1, 1);
    pulses = 0;
    drive(1, 1, 0, 10);
    chk("R5 re-armed pulse", pulses, 1);
    drive(1, 1, 1, 3);

    // R6: ready blip restarts full count
    cur_req = "R6"; setv(1, 4); pulses = 0;
    drive(1, 1, 0, 6);
    drive(1, 1, 1, 1);
    chk("R6 no pulse before restart", pulses, 0);
    drive(1, 1, 0, 30);
    chk("R6 pulse after restart", pulses, 1);
    drive(1, 1, 1, 3);

    // R6: pending drop stops
    cur_req = "R6"; setv(1, 3); pulses = 0;
    drive(1, 1, 0, 5);
    drive(1, 0, 0, 4);
    chk("R6 pending drop stops", pulses, 0);

    // R6: stop coincides with expiry edge (P=1,T=2 -> edge arm+4)
    cur_req = "R6"; setv(1, 2); pulses = 0;
    drive(1, 1, 0, 4);   // arming edge + 3 more
    drive(1, 1, 1, 6);   // release lands on the expiry edge
    chk("R6 ready on expiry edge", pulses, 0);
    drive(1, 1, 0, 4);
    drive(1, 0, 0, 6);
    chk("R6 pending drop on expiry edge", pulses, 0);

    // R7: enable cleared before expiry
    cur_req = "R7"; setv(2, 4); pulses = 0;
    drive(1, 1, 0, 8);
    drive(0, 1, 0, 30);
    chk("R7 disable suppresses", pulses, 0);

    // R2: never arms without the full stall condition
    cur_req = "R2"; setv(0, 1); pulses = 0;
    drive(0, 1, 0, 10);
    drive(1, 0, 0, 10);
    drive(1, 1, 1, 10);
    chk("R2 no arming", pulses, 0);

    // R8: values captured at arming
    cur_req = "R8"; setv(1, 3); pulses = 0;
    drive(1, 1, 0, 2);
    setv(7, 40);
    drive(1, 1, 0, 20);
    chk("R8 captured values", pulses, 1);
    drive(1, 1, 1, 3);

    // R4: pulse width over a short-period run
    cur_req = "R4"; setv(0, 1); pulses = 0;
    drive(1, 1, 0, 6);
    chk("R4 single-cycle pulse", pulses, 1);
    drive(1, 1, 1, 3);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule